// File: doc/BRIEF.md
# Dual-Channel Register Bank with Shared Vector and Indirect Pointer

This block is the host-facing register layer of a two-channel serial controller. The host reaches every register of a channel through that channel's register 0. A write to register 0 loads a register pointer, and the next access on the same channel goes to the register that the pointer selects. After that access the pointer falls back to 0. Each channel keeps its own set of write registers. These cover control, sync characters, transmit data and the baud time constants. Two registers, the interrupt vector and the master interrupt control register, exist only once and can be reached from both channels.

Read data comes from the stored write values, from status inputs or from a mix of the two. Which source is used depends on the register, on the channel and on two enable bits in each channel's configuration register. A read of the vector depends on the channel: through channel A it returns the stored byte, and through channel B it returns the same byte with a priority code of the pending interrupts in bits 3:1. The serializers, the baud generators and the interrupt priority chain are not part of this block. Pending bits and status arrive as plain inputs.

Top module: `dual_regbank`

## Requirements
- R1: A write to register 0 on a channel loads bits [3:0] of the data into that channel's pointer. The next read or write on that channel targets the selected register. The pointer of the other channel is not affected.
- R2: After a read or write of a non-zero register, that channel's pointer is 0. An access made while the pointer is 0 targets register 0, and a read there returns the channel's `st0` input.
- R3: Registers 2 (vector) and 9 (master interrupt control) each have a single copy. A write through either channel is seen by reads from both channels, and register 9 reads back directly.
- R4: A read of register 2 through channel A (`ch_sel`=0) returns the stored vector unchanged.
- R5: A read of register 2 through channel B (`ch_sel`=1) returns the vector with bits 3:1 replaced by a code. The code is k+1, where k is the highest set bit of `pend_i` (bit 5 has the highest priority). The code is 0 when no bit is set. Bits 7:4 and bit 0 keep their stored values.
- R6: A read of register 3 through channel A returns `pend_i` zero-extended. Through channel B it returns 0.
- R7: Reads of registers 6 and 7 return the channel's `fs_lo` and `fs_hi` inputs while bit 2 of that channel's register 15 is 1. Otherwise they return 0.
- R8: While bit 0 of a channel's register 15 is 1, reads of registers 4, 5, 10, 11, 14 and 15 return the values last written to them. While that bit is 0, these reads return 0.
- R9: Reads of registers 12 and 13 always return the channel's baud time-constant write registers.
- R10: A synchronous reset clears both pointers, register 9 and every per-channel register. The vector register keeps its value through reset.
- R11: Reads of registers 1 and 8 return the channel's `st1` and `rxd` inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe. It has priority when `rd_en` is also high |
| rd_en | input | 1 | Read strobe |
| ch_sel | input | 1 | Channel select: 0 = A, 1 = B |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| pend_i | input | 6 | Interrupt-pending bits, bit 5 has the highest priority |
| st0_i | input | 16 | Status 0; [7:0] for channel A, [15:8] for channel B |
| st1_i | input | 16 | Status 1, per channel as above |
| rxd_i | input | 16 | Receive data, per channel as above |
| fs_lo_i | input | 16 | Frame-status low byte, per channel as above |
| fs_hi_i | input | 16 | Frame-status high byte, per channel as above |

## Verification
`rdata` is combinational from the current pointer and storage. It is therefore due in the same cycle as the `rd_en` strobe. The bench drives every access just after a falling edge and samples `rdata` one time unit later, before the rising edge. A pointer load or a register write takes effect at the rising edge of its strobe cycle. So the earliest access that can observe it is the strobe in the following cycle, and the bench always issues the follow-up access one full cycle later. The shared-register, enable-bit and reset results are also checked one access after the write that sets them up. None of them relies on the same-cycle read.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int AW   = 4;
    localparam int NREG = 1 << AW;
    localparam int NCH  = 2;

    localparam logic [AW-1:0] ADR_CMD   = 4'd0;
    localparam logic [AW-1:0] ADR_ST1   = 4'd1;
    localparam logic [AW-1:0] ADR_VEC   = 4'd2;
    localparam logic [AW-1:0] ADR_PEND  = 4'd3;
    localparam logic [AW-1:0] ADR_X4    = 4'd4;
    localparam logic [AW-1:0] ADR_X5    = 4'd5;
    localparam logic [AW-1:0] ADR_FSLO  = 4'd6;
    localparam logic [AW-1:0] ADR_FSHI  = 4'd7;
    localparam logic [AW-1:0] ADR_DATA  = 4'd8;
    localparam logic [AW-1:0] ADR_MIC   = 4'd9;
    localparam logic [AW-1:0] ADR_X10   = 4'd10;
    localparam logic [AW-1:0] ADR_X11   = 4'd11;
    localparam logic [AW-1:0] ADR_TCLO  = 4'd12;
    localparam logic [AW-1:0] ADR_TCHI  = 4'd13;
    localparam logic [AW-1:0] ADR_X14   = 4'd14;
    localparam logic [AW-1:0] ADR_CFG   = 4'd15;

    localparam int CFG_EXT_BIT = 0;
    localparam int CFG_FS_BIT  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;
endpackage

// File: rtl/regbank_ptr.sv
module regbank_ptr
    import regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          wr_i,
    input  logic [AW-1:0] sel_i,
    output logic [AW-1:0] ptr_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_i) begin
            if (st_q.ptr != ADR_CMD) st_d.ptr = ADR_CMD;
            else if (wr_i)          st_d.ptr = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_i && st_q.ptr == ADR_CMD) |=> (ptr_o == $past(sel_i)));

    // R2
    ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && ptr_o != ADR_CMD) |=> (ptr_o == ADR_CMD));
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_i,
    input  logic                            ch_i,
    input  logic [AW-1:0]                   addr_i,
    input  logic [DW-1:0]                   wdata_i,
    output logic [DW-1:0]                   vec_o,
    output logic [DW-1:0]                   mic_o,
    output logic [NCH-1:0][NREG-1:0][DW-1:0] regs_o
);
    typedef struct packed {
        logic [DW-1:0]                   mic;
        logic [NCH-1:0][NREG-1:0][DW-1:0] regs;
    } store_st_t;

    store_st_t     st_d, st_q;
    logic [DW-1:0] vec_d, vec_q;

    always_comb begin
        st_d  = st_q;
        vec_d = vec_q;
        if (wr_i) begin
            unique case (addr_i)
                ADR_CMD: ;
                ADR_VEC: vec_d = wdata_i;
                ADR_MIC: st_d.mic = wdata_i;
                default: st_d.regs[ch_i][addr_i] = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        vec_q <= vec_d;
    end

    assign vec_o  = vec_q;
    assign mic_o  = st_q.mic;
    assign regs_o = st_q.regs;

    // R3
    mic_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_MIC) |=> (mic_o == $past(wdata_i)));

    // R3
    vec_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_VEC) |=> (vec_o == $past(wdata_i)));
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import regbank_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = 6
) (
    input  logic                             ch_i,
    input  logic [AW-1:0]                    addr_i,
    input  logic [NCH-1:0][NREG-1:0][DW-1:0] regs_i,
    input  logic [DW-1:0]                    vec_i,
    input  logic [DW-1:0]                    mic_i,
    input  logic [NSRC-1:0]                  pend_i,
    input  logic [NCH-1:0][DW-1:0]           st0_i,
    input  logic [NCH-1:0][DW-1:0]           st1_i,
    input  logic [NCH-1:0][DW-1:0]           rxd_i,
    input  logic [NCH-1:0][DW-1:0]           fslo_i,
    input  logic [NCH-1:0][DW-1:0]           fshi_i,
    output logic [DW-1:0]                    rdata_o
);
    localparam int CW = 3;

    logic [CW-1:0] code;
    logic [DW-1:0] vec_mod;
    logic [DW-1:0] cfg;
    logic          ext_en, fs_en;

    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) code = CW'(i + 1);
        end
    end

    always_comb begin
        vec_mod        = vec_i;
        vec_mod[CW:1]  = code;
    end

    assign cfg    = regs_i[ch_i][ADR_CFG];
    assign ext_en = cfg[CFG_EXT_BIT];
    assign fs_en  = cfg[CFG_FS_BIT];

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_CMD:  rdata_o = st0_i[ch_i];
            ADR_ST1:  rdata_o = st1_i[ch_i];
            ADR_VEC:  rdata_o = (ch_i == 1'(CH_B)) ? vec_mod : vec_i;
            ADR_PEND: rdata_o = (ch_i == 1'(CH_A)) ? DW'(pend_i) : '0;
            ADR_FSLO: rdata_o = fs_en ? fslo_i[ch_i] : '0;
            ADR_FSHI: rdata_o = fs_en ? fshi_i[ch_i] : '0;
            ADR_DATA: rdata_o = rxd_i[ch_i];
            ADR_MIC:  rdata_o = mic_i;
            ADR_TCLO, ADR_TCHI: rdata_o = regs_i[ch_i][addr_i];
            ADR_X4, ADR_X5, ADR_X10, ADR_X11, ADR_X14, ADR_CFG:
                      rdata_o = ext_en ? regs_i[ch_i][addr_i] : '0;
            default:  rdata_o = '0;
        endcase
    end

    // R6
    always_comb begin
        if (addr_i == ADR_PEND && ch_i == 1'(CH_B))
            pend_hidden_chk: assert (rdata_o == '0);
    end

    // R5
    always_comb begin
        if (addr_i == ADR_VEC && ch_i == 1'(CH_B) && pend_i == '0)
            vec_nocode_chk: assert (rdata_o[CW:1] == '0);
    end
endmodule

// File: rtl/dual_regbank.sv
module dual_regbank
    import regbank_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              ch_sel,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NSRC-1:0]   pend_i,
    input  logic [NCH*DW-1:0] st0_i,
    input  logic [NCH*DW-1:0] st1_i,
    input  logic [NCH*DW-1:0] rxd_i,
    input  logic [NCH*DW-1:0] fs_lo_i,
    input  logic [NCH*DW-1:0] fs_hi_i
);
    logic [NCH-1:0][AW-1:0]            ptr;
    logic [AW-1:0]                     addr;
    logic [DW-1:0]                     vec, mic;
    logic [NCH-1:0][NREG-1:0][DW-1:0]  regs;
    logic                              acc;

    assign acc = wr_en | rd_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ptr
        regbank_ptr u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .acc_i (acc && (ch_sel == 1'(c))),
            .wr_i  (wr_en),
            .sel_i (wdata[AW-1:0]),
            .ptr_o (ptr[c])
        );
    end

    assign addr = ptr[ch_sel];

    regbank_store #(.DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .ch_i    (ch_sel),
        .addr_i  (addr),
        .wdata_i (wdata),
        .vec_o   (vec),
        .mic_o   (mic),
        .regs_o  (regs)
    );

    regbank_rdmux #(.DW(DW), .NSRC(NSRC)) u_rdmux (
        .ch_i    (ch_sel),
        .addr_i  (addr),
        .regs_i  (regs),
        .vec_i   (vec),
        .mic_i   (mic),
        .pend_i  (pend_i),
        .st0_i   (st0_i),
        .st1_i   (st1_i),
        .rxd_i   (rxd_i),
        .fslo_i  (fs_lo_i),
        .fshi_i  (fs_hi_i),
        .rdata_o (rdata)
    );
endmodule

// File: tb/dual_regbank_tb.sv
module dual_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, ch_sel = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [5:0]  pend_i = '0;
    logic [15:0] st0_i   = 16'hB0A0;
    logic [15:0] st1_i   = 16'hB1A1;
    logic [15:0] rxd_i   = 16'hB8A8;
    logic [15:0] fs_lo_i = 16'hB6A6;
    logic [15:0] fs_hi_i = 16'hB7A7;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    dual_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ch_sel(ch_sel),
        .wdata(wdata), .rdata(rdata), .pend_i(pend_i), .st0_i(st0_i),
        .st1_i(st1_i), .rxd_i(rxd_i), .fs_lo_i(fs_lo_i), .fs_hi_i(fs_hi_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic ch, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = ~w; ch_sel = ch; wdata = d;
        #1 got = rdata;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr_reg(input logic ch, input logic [3:0] a, input logic [7:0] d);
        if (a != 0) access(1'b1, ch, {4'h0, a});
        access(1'b1, ch, d);
        idle();
    endtask

    task automatic rd_reg(input logic ch, input logic [3:0] a, input logic [7:0] exp, input string tag);
        if (a != 0) access(1'b1, ch, {4'h0, a});
        access(1'b0, ch, 8'h00);
        check(tag, got, exp);
        idle();
    endtask

    function automatic logic [2:0] prio_code(input logic [5:0] p);
        logic [2:0] c = 3'd0;
        for (int i = 0; i < 6; i++) if (p[i]) c = 3'(i + 1);
        return c;
    endfunction

    task automatic t_reset();
        rd_reg(1'b0, 4'd0, 8'hA0, "R10 reset ptr A");
        rd_reg(1'b1, 4'd9, 8'h00, "R10 reset mic");
        rd_reg(1'b0, 4'd12, 8'h00, "R10 reset tc A");
    endtask

    task automatic t_pointer();
        access(1'b1, 1'b0, 8'h08);
        idle();
        rd_reg(1'b1, 4'd0, 8'hB0, "R1 B unaffected by A ptr");
        access(1'b0, 1'b0, 8'h00);
        check("R1 A ptr selects rxd", got, 8'hA8);
        idle();
        rd_reg(1'b0, 4'd0, 8'hA0, "R2 ptr back to 0 after read");
        wr_reg(1'b0, 4'd12, 8'h77);
        rd_reg(1'b0, 4'd0, 8'hA0, "R2 ptr back to 0 after write");
        rd_reg(1'b1, 4'd1, 8'hB1, "R11 st1 B");
        rd_reg(1'b0, 4'd8, 8'hA8, "R11 rxd A");
    endtask

    task automatic t_shared();
        wr_reg(1'b0, 4'd9, 8'h3C);
        rd_reg(1'b1, 4'd9, 8'h3C, "R3 mic via B");
        wr_reg(1'b1, 4'd9, 8'hC3);
        rd_reg(1'b0, 4'd9, 8'hC3, "R3 mic via A");
        wr_reg(1'b1, 4'd2, 8'h5B);
        rd_reg(1'b0, 4'd2, 8'h5B, "R3 R4 vector written via B read via A");
    endtask

    task automatic t_vector();
        logic [5:0] pats [4] = '{6'b000000, 6'b000001, 6'b100100, 6'b001010};
        wr_reg(1'b0, 4'd2, 8'hF1);
        for (int i = 0; i < 4; i++) begin
            pend_i = pats[i];
            rd_reg(1'b1, 4'd2, {4'hF, prio_code(pats[i]), 1'b1}, "R5 vector via B");
            rd_reg(1'b0, 4'd2, 8'hF1, "R4 vector via A");
        end
    endtask

    task automatic t_pending();
        pend_i = 6'b101101;
        rd_reg(1'b0, 4'd3, 8'h2D, "R6 pending via A");
        rd_reg(1'b1, 4'd3, 8'h00, "R6 pending hidden via B");
        pend_i = '0;
    endtask

    task automatic t_fifo();
        rd_reg(1'b0, 4'd6, 8'h00, "R7 fs lo disabled");
        wr_reg(1'b0, 4'd15, 8'h04);
        rd_reg(1'b0, 4'd6, 8'hA6, "R7 fs lo enabled A");
        rd_reg(1'b0, 4'd7, 8'hA7, "R7 fs hi enabled A");
        rd_reg(1'b1, 4'd7, 8'h00, "R7 fs hi disabled B");
    endtask

    task automatic t_ext();
        wr_reg(1'b0, 4'd4, 8'h5A);
        wr_reg(1'b0, 4'd15, 8'h00);
        rd_reg(1'b0, 4'd4, 8'h00, "R8 readback off");
        wr_reg(1'b0, 4'd15, 8'h01);
        rd_reg(1'b0, 4'd4, 8'h5A, "R8 readback reg4");
        rd_reg(1'b0, 4'd15, 8'h01, "R8 readback reg15");
        wr_reg(1'b1, 4'd14, 8'h33);
        rd_reg(1'b1, 4'd14, 8'h00, "R8 B readback off");
    endtask

    task automatic t_baud();
        wr_reg(1'b0, 4'd12, 8'h12);
        wr_reg(1'b0, 4'd13, 8'h34);
        wr_reg(1'b1, 4'd12, 8'h56);
        rd_reg(1'b0, 4'd12, 8'h12, "R9 tc lo A");
        rd_reg(1'b0, 4'd13, 8'h34, "R9 tc hi A");
        rd_reg(1'b1, 4'd12, 8'h56, "R9 tc lo B");
    endtask

    task automatic t_reset_keep();
        wr_reg(1'b0, 4'd2, 8'h9E);
        wr_reg(1'b0, 4'd9, 8'h44);
        access(1'b1, 1'b0, 8'h08);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(1'b0, 4'd0, 8'hA0, "R10 ptr cleared by reset");
        rd_reg(1'b0, 4'd2, 8'h9E, "R10 vector kept");
        rd_reg(1'b0, 4'd9, 8'h00, "R10 mic cleared");
        rd_reg(1'b1, 4'd12, 8'h00, "R10 tc B cleared");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_shared();
        t_vector();
        t_pending();
        t_fifo();
        t_ext();
        t_baud();
        t_reset_keep();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule